// File: doc/BRIEF.md
# SPI Slave-Mode FPGA Configuration Loader

This block configures a target FPGA that boots from an external SPI master. After a start pulse it pulls the target's active-low reset and its chip select low together and holds them there. It checks that the target's configuration-done pin is low and then releases reset. After a settling wait it raises chip select and sends a burst of dummy clocks. It then lowers chip select and streams the image bytes, which arrive on a valid/ready interface. Chip select goes back up for a second burst of dummy clocks, and the block finally checks that configuration-done has gone high.

The serial link uses SPI mode 3. The clock idles high, and data changes on the falling edge so that the target samples on the rising edge. One serial half period lasts `HALF` system clocks. The delays are counted in system clocks and the dummy-clock requests in serial clocks. All four values come from input ports that the block samples only on the start cycle. While the image streams out, a running IEEE CRC-32 of the sent bytes is reported. The busy, success, error and loaded outputs tell the host how the last load ended.

Top module: `spi_cfg_loader`

## Requirements
- R1: Out of reset and whenever idle: busy=0, tgt_rst_n=1, tgt_cs_n=1, tgt_sclk=1, tgt_mosi=1, img_ready=0. Out of reset: ok=0, err=0, loaded=0, crc=0.
- R2: A start seen while idle raises busy and lowers tgt_rst_n and tgt_cs_n on the same edge. tgt_rst_n then stays low for rst_dly+1 clocks. A start while busy is ignored, and input values that change after the start cycle have no effect on the current load.
- R3: If tgt_done reads 1 at the end of the reset hold, the load ends with err=1 and ok=0, and no serial clock is sent.
- R4: After tgt_rst_n rises, tgt_cs_n stays low for cfg_dly+1 clocks and then goes high.
- R5: With tgt_cs_n high, the block sends ceil(lead_clks/8)*8 leading serial clock pulses with tgt_mosi=1.
- R6: The image bytes are sent most significant bit first in SPI mode 3. tgt_cs_n stays low from the first image bit through the last.
- R7: After the image, tgt_cs_n returns high and the block sends ceil(trail_clks/8)*8 trailing pulses with tgt_mosi=1.
- R8: After the trailing pulses, tgt_done=1 gives ok=1 and loaded=1. tgt_done=0 gives err=1, ok=0 and loaded=0.
- R9: On every exit, success or error, busy falls and tgt_rst_n and tgt_cs_n are both driven high.
- R10: crc is the reflected IEEE CRC-32 of the accepted image bytes (polynomial 0xEDB88320, initial value and final XOR all ones). For the ASCII bytes "123456789" it is 0xCBF43926, and for one 0x00 byte it is 0xD202EF8D.
- R11: A start clears loaded, ok and err. Once idle, ok and err hold their values until the next start.
- R12: img_ready is asserted only while busy with tgt_cs_n low in the image phase, and one byte is accepted per handshake. img_last marks the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a load when idle |
| rst_dly | input | CNT_W | Reset hold length minus one, in clocks |
| cfg_dly | input | CNT_W | Post-reset wait minus one, in clocks |
| lead_clks | input | CNT_W | Leading dummy clocks requested |
| trail_clks | input | CNT_W | Trailing dummy clocks requested |
| img_data | input | 8 | Image byte |
| img_valid | input | 1 | Image byte present |
| img_last | input | 1 | Current byte is the final one |
| img_ready | output | 1 | Block accepts the image byte |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_cs_n | output | 1 | Target chip select, active low |
| tgt_sclk | output | 1 | Serial clock, idles high |
| tgt_mosi | output | 1 | Serial data to target |
| tgt_done | input | 1 | Target configuration-done pin |
| busy | output | 1 | Load in progress |
| ok | output | 1 | Last load succeeded |
| err | output | 1 | Last load failed |
| loaded | output | 1 | Target holds a verified image |
| crc | output | 32 | CRC-32 of bytes sent so far |

## Verification
The bench goes after the rounding of the dummy-clock counts: 13 requested clocks must give 16, 9 must give 16, and 0 must give none. A design that forgot to round up, or sent a byte when none was asked, would show the wrong pulse count. It drives tgt_done high during the reset hold, which must abort before any serial clock, and it holds tgt_done low at the end, which must set err and leave loaded low. A design that skipped either check would report success. A second start and changed input values in the middle of a load must leave the pulse counts and the captured bytes unchanged. Known CRC check values expose a wrong bit order or a missing final inversion.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_CFG,
    S_LEAD,
    S_IMG,
    S_TRAIL
  } seq_e;

  // one byte of reflected IEEE CRC-32, LSB first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_cfg_byte_tx.sv
module spi_cfg_byte_tx #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] byte_in,
  output logic       sclk,
  output logic       mosi,
  output logic       done
);
  localparam int DW = $clog2(HALF) + 1;
  localparam logic [DW-1:0] DIV_END = DW'(HALF - 1);

  logic          act_q, act_d;
  logic          ph_q, ph_d;
  logic [2:0]    bit_q, bit_d;
  logic [DW-1:0] div_q, div_d;
  logic [7:0]    sh_q, sh_d;
  logic          tick;

  assign tick = act_q && (div_q == DIV_END);
  assign done = tick && ph_q && (bit_q == 3'd7);
  assign sclk = !act_q || ph_q;
  assign mosi = act_q ? sh_q[7] : 1'b1;

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    bit_d = bit_q;
    div_d = div_q;
    sh_d  = sh_q;
    if (!act_q) begin
      if (go) begin
        act_d = 1'b1;
        ph_d  = 1'b0;
        bit_d = 3'd0;
        div_d = '0;
        sh_d  = byte_in;
      end
    end else if (!tick) begin
      div_d = div_q + 1'b1;
    end else begin
      div_d = '0;
      if (!ph_q) begin
        ph_d = 1'b1;
      end else if (bit_q == 3'd7) begin
        act_d = 1'b0;
      end else begin
        ph_d  = 1'b0;
        bit_d = bit_q + 1'b1;
        sh_d  = {sh_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= 1'b1;
      bit_q <= '0;
      div_q <= '0;
      sh_q  <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      div_q <= div_d;
      sh_q  <= sh_d;
    end
  end
endmodule

// File: rtl/spi_cfg_crc32.sv
module spi_cfg_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import spi_cfg_pkg::*;

  logic [31:0] acc_q, acc_d;

  assign crc = ~acc_q;

  always_comb begin
    acc_d = acc_q;
    if (clr)     acc_d = 32'hFFFF_FFFF;
    else if (en) acc_d = crc32_step(acc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 32'hFFFF_FFFF;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader #(
  parameter int HALF  = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] rst_dly,
  input  logic [CNT_W-1:0] cfg_dly,
  input  logic [CNT_W-1:0] lead_clks,
  input  logic [CNT_W-1:0] trail_clks,
  input  logic [7:0]       img_data,
  input  logic             img_valid,
  input  logic             img_last,
  output logic             img_ready,
  output logic             tgt_rst_n,
  output logic             tgt_cs_n,
  output logic             tgt_sclk,
  output logic             tgt_mosi,
  input  logic             tgt_done,
  output logic             busy,
  output logic             ok,
  output logic             err,
  output logic             loaded,
  output logic [31:0]      crc
);
  import spi_cfg_pkg::*;

  localparam logic [CNT_W:0] RND = (CNT_W + 1)'(7);

  seq_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cfg_q, cfg_d, trl_q, trl_d;
  logic             pend_q, pend_d, last_q, last_d;
  logic             rsn_q, rsn_d, csn_q, csn_d;
  logic             busy_q, busy_d, ok_q, ok_d, err_q, err_d, ld_q, ld_d;
  logic             go, tx_done, crc_clr, acc;
  logic [7:0]       go_byte;

  function automatic logic [CNT_W-1:0] to_bytes(input logic [CNT_W-1:0] n);
    return CNT_W'(({1'b0, n} + RND) >> 3);
  endfunction

  assign img_ready = (st_q == S_IMG) && !pend_q && !last_q;
  assign acc       = img_ready && img_valid;

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q; cfg_d = cfg_q; trl_d = trl_q;
    pend_d = pend_q; last_d = last_q; rsn_d = rsn_q; csn_d = csn_q;
    busy_d = busy_q; ok_d = ok_q; err_d = err_q; ld_d = ld_q;
    go = 1'b0; go_byte = 8'hFF; crc_clr = 1'b0;
    if (tx_done) pend_d = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        st_d = S_RST; rsn_d = 1'b0; csn_d = 1'b0; busy_d = 1'b1;
        ok_d = 1'b0; err_d = 1'b0; ld_d = 1'b0; last_d = 1'b0;
        cnt_d = rst_dly; cfg_d = cfg_dly; trl_d = to_bytes(trail_clks);
        crc_clr = 1'b1;
      end
      S_RST: if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (tgt_done) begin
          err_d = 1'b1; st_d = S_IDLE; rsn_d = 1'b1; csn_d = 1'b1; busy_d = 1'b0;
        end else begin
          rsn_d = 1'b1; cnt_d = cfg_q; st_d = S_CFG;
        end
      S_CFG: if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else begin
          csn_d = 1'b1; cnt_d = to_bytes(lead_q_hold); st_d = S_LEAD;
        end
      S_LEAD: if (!pend_q) begin
        if (cnt_q == '0) begin
          csn_d = 1'b0; st_d = S_IMG;
        end else begin
          go = 1'b1; pend_d = 1'b1; cnt_d = cnt_q - 1'b1;
        end
      end
      S_IMG: if (acc) begin
        go = 1'b1; go_byte = img_data; pend_d = 1'b1; last_d = img_last;
      end else if (!pend_q && last_q) begin
        csn_d = 1'b1; cnt_d = trl_q; st_d = S_TRAIL;
      end
      S_TRAIL: if (!pend_q) begin
        if (cnt_q == '0) begin
          ok_d = tgt_done; ld_d = tgt_done; err_d = !tgt_done;
          st_d = S_IDLE; rsn_d = 1'b1; csn_d = 1'b1; busy_d = 1'b0;
        end else begin
          go = 1'b1; pend_d = 1'b1; cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // leading count is captured at start alongside the other settings
  logic [CNT_W-1:0] lead_q_hold, lead_d_hold;
  always_comb lead_d_hold = (st_q == S_IDLE && start) ? lead_clks : lead_q_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; cfg_q <= '0; trl_q <= '0; lead_q_hold <= '0;
      pend_q <= 1'b0; last_q <= 1'b0; rsn_q <= 1'b1; csn_q <= 1'b1;
      busy_q <= 1'b0; ok_q <= 1'b0; err_q <= 1'b0; ld_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; cfg_q <= cfg_d; trl_q <= trl_d; lead_q_hold <= lead_d_hold;
      pend_q <= pend_d; last_q <= last_d; rsn_q <= rsn_d; csn_q <= csn_d;
      busy_q <= busy_d; ok_q <= ok_d; err_q <= err_d; ld_q <= ld_d;
    end
  end

  spi_cfg_byte_tx #(.HALF(HALF)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(go), .byte_in(go_byte),
    .sclk(tgt_sclk), .mosi(tgt_mosi), .done(tx_done)
  );

  spi_cfg_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(acc), .din(img_data), .crc(crc)
  );

  assign tgt_rst_n = rsn_q;
  assign tgt_cs_n  = csn_q;
  assign busy      = busy_q;
  assign ok        = ok_q;
  assign err       = err_q;
  assign loaded    = ld_q;
endmodule

// File: rtl/spi_cfg_loader_chk.sv
module spi_cfg_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic img_ready,
  input logic tgt_rst_n,
  input logic tgt_cs_n,
  input logic tgt_sclk,
  input logic tgt_mosi,
  input logic busy,
  input logic ok,
  input logic err,
  input logic loaded
);
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tgt_rst_n && tgt_cs_n && tgt_sclk && tgt_mosi && !img_ready));

  a_r2_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !tgt_rst_n && !tgt_cs_n));

  a_r3_no_clock_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> tgt_sclk);

  a_r9_exit_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (tgt_rst_n && tgt_cs_n && (ok || err)));

  a_r11_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(ok) && $stable(err) && $stable(loaded)));

  a_r11_loaded_clear: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !loaded);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && err));

  a_r12_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready |-> (busy && !tgt_cs_n && tgt_rst_n));
endmodule

bind spi_cfg_loader spi_cfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .img_ready(img_ready),
  .tgt_rst_n(tgt_rst_n), .tgt_cs_n(tgt_cs_n), .tgt_sclk(tgt_sclk),
  .tgt_mosi(tgt_mosi), .busy(busy), .ok(ok), .err(err), .loaded(loaded)
);

// File: tb/tb_spi_cfg_loader.sv
module tb_spi_cfg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] rst_dly = '0, cfg_dly = '0, lead_clks = '0, trail_clks = '0;
  logic [7:0] img_data = '0;
  logic img_valid = 1'b0, img_last = 1'b0, tgt_done = 1'b0;
  logic img_ready, tgt_rst_n, tgt_cs_n, tgt_sclk, tgt_mosi, busy, ok, err, loaded;
  logic [31:0] crc;

  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] img [0:15];
  logic [7:0] rx  [0:15];
  int rx_n, nbit, lead_n, trail_n, mosi_bad, rst_low, cfg_low, sclk_rst;
  logic [7:0] cur;
  logic seen_hi, finished;

  always #4 clk = ~clk;

  spi_cfg_loader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rst_dly(rst_dly), .cfg_dly(cfg_dly),
    .lead_clks(lead_clks), .trail_clks(trail_clks), .img_data(img_data),
    .img_valid(img_valid), .img_last(img_last), .img_ready(img_ready),
    .tgt_rst_n(tgt_rst_n), .tgt_cs_n(tgt_cs_n), .tgt_sclk(tgt_sclk),
    .tgt_mosi(tgt_mosi), .tgt_done(tgt_done), .busy(busy), .ok(ok), .err(err),
    .loaded(loaded), .crc(crc)
  );

  // target model: capture on rising serial clock
  always @(posedge tgt_sclk) if (rst_n) begin
    if (!tgt_rst_n) sclk_rst++;
    if (!tgt_cs_n) begin
      cur = {cur[6:0], tgt_mosi};
      nbit++;
      if (nbit == 8) begin rx[rx_n] = cur; rx_n++; nbit = 0; end
    end else begin
      if (!tgt_mosi) mosi_bad++;
      if (rx_n == 0) lead_n++; else trail_n++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (busy && !tgt_rst_n) rst_low++;
    if (busy && tgt_rst_n && tgt_cs_n) seen_hi = 1'b1;
    if (busy && tgt_rst_n && !tgt_cs_n && !seen_hi) cfg_low++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    rx_n = 0; nbit = 0; lead_n = 0; trail_n = 0; mosi_bad = 0;
    rst_low = 0; cfg_low = 0; sclk_rst = 0; seen_hi = 1'b0; cur = '0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      if (finished) break;
      @(negedge clk);
      img_valid = 1'b1; img_data = img[i]; img_last = (i == n - 1);
      while (!img_ready && !finished) @(negedge clk);
    end
    @(negedge clk);
    img_valid = 1'b0; img_last = 1'b0;
  endtask

  // done_mode: 0 low throughout, 1 rises after reset release, 2 high throughout
  task automatic run_load(input int rd, input int cd, input int ld, input int td,
                          input int n, input int done_mode, input bit poke);
    clear_mon();
    finished = 1'b0;
    rst_dly = 16'(rd); cfg_dly = 16'(cd); lead_clks = 16'(ld); trail_clks = 16'(td);
    tgt_done = (done_mode == 2);
    fork
      feed(n);
      begin
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R11 loaded cleared while busy", {30'b0, busy, loaded}, 32'h2);
        if (poke) begin
          rst_dly = 16'd3; cfg_dly = 16'd1; lead_clks = 16'd40; trail_clks = 16'd40;
          repeat (60) @(negedge clk);
          start = 1'b1; @(negedge clk); start = 1'b0;
        end
        if (done_mode == 1) begin
          wait (tgt_rst_n == 1'b1);
          @(negedge clk); tgt_done = 1'b1;
        end
        for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
        chk("R9 busy released", {31'b0, busy}, 32'h0);
        finished = 1'b1;
      end
    join
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset lines", {26'b0, busy, tgt_rst_n, tgt_cs_n, tgt_sclk, tgt_mosi, img_ready},
        32'b011110);
    chk("R1 reset status", {29'b0, ok, err, loaded}, 32'h0);
    chk("R1 reset crc", crc, 32'h0);
  endtask

  task automatic t_good();
    byte s[9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    for (int i = 0; i < 9; i++) img[i] = s[i];
    run_load(30, 5, 8, 13, 9, 1, 1'b1);
    chk("R2 reset hold", 32'(rst_low), 32'd31);
    chk("R4 config wait", 32'(cfg_low), 32'd6);
    chk("R5 leading pulses", 32'(lead_n), 32'd8);
    chk("R7 trailing rounded", 32'(trail_n), 32'd16);
    chk("R5 R7 dummy mosi high", 32'(mosi_bad), 32'd0);
    chk("R6 byte count", 32'(rx_n), 32'd9);
    for (int i = 0; i < 9; i++) chk("R6 image byte msb first", {24'b0, rx[i]}, {24'b0, img[i]});
    chk("R8 success status", {29'b0, ok, err, loaded}, 32'b101);
    chk("R10 crc check value", crc, 32'hCBF4_3926);
    chk("R9 exit lines", {30'b0, tgt_rst_n, tgt_cs_n}, 32'h3);
    repeat (40) @(negedge clk);
    chk("R11 status held", {29'b0, ok, err, loaded}, 32'b101);
  endtask

  task automatic t_early_done();
    run_load(12, 2, 8, 8, 2, 2, 1'b0);
    chk("R3 error status", {29'b0, ok, err, loaded}, 32'b010);
    chk("R3 reset hold", 32'(rst_low), 32'd13);
    chk("R3 no serial clocks", 32'(lead_n + trail_n + rx_n + nbit), 32'd0);
    chk("R9 exit lines after abort", {30'b0, tgt_rst_n, tgt_cs_n}, 32'h3);
  endtask

  task automatic t_no_done();
    img[0] = 8'hA5; img[1] = 8'h3C;
    run_load(4, 0, 9, 1, 2, 0, 1'b0);
    chk("R5 nine rounds to sixteen", 32'(lead_n), 32'd16);
    chk("R7 one rounds to eight", 32'(trail_n), 32'd8);
    chk("R6 first byte", {24'b0, rx[0]}, 32'hA5);
    chk("R6 second byte", {24'b0, rx[1]}, 32'h3C);
    chk("R8 missing done error", {29'b0, ok, err, loaded}, 32'b010);
    chk("R9 exit lines after error", {30'b0, tgt_rst_n, tgt_cs_n}, 32'h3);
  endtask

  task automatic t_zero_lead();
    img[0] = 8'h00;
    run_load(0, 0, 0, 1, 1, 1, 1'b0);
    chk("R5 zero leading pulses", 32'(lead_n), 32'd0);
    chk("R12 single byte accepted", 32'(rx_n), 32'd1);
    chk("R10 crc single zero byte", crc, 32'hD202_EF8D);
    chk("R8 success again", {29'b0, ok, err, loaded}, 32'b101);
    chk("R2 no clocks during reset", 32'(sclk_rst), 32'd0);
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_early_done();
    t_no_done();
    t_zero_lead();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule